// File: doc/BRIEF.md
# Trace Trap and Interrupt Boundary Sequencer

This block decides, at every instruction boundary of a 16-bit minicomputer-style CPU, what the core does next. An abort vector comes first, then the vector of a trap instruction, then an interrupt of higher priority than the processor, then a pending trace trap, and only then the fetch of the next instruction. A pending trace flag is loaded when an instruction completes. Its value depends on the opcode class, the processor mode, the current trace bit, and the trace bit of a PS restored by a return instruction.

The datapath pushes the trap frame. It reports the push through a valid/ready service handshake. `svc_valid` rises with a vector on `svc_vec`. Both stay stable while `svc_ready` is low, and the transfer happens on the cycle where both are high. The datapath may hold `svc_ready` low for any number of cycles. Completion and abort strobes are counted only while the core is executing, which is after a fetch grant and before the next boundary.

A RESET instruction holds the sequencer in a fixed wait. At the end of the wait it pulses a cancel to the software interrupt request logic and masks interrupts for that one boundary. Any trace trap owed by the RESET is still raised after the wait.

Top module: `trace_irq_seq`

## Requirements
- R1: After synchronous reset, `svc_valid`, `fetch_go`, `reset_busy` and `pirq_cancel` are all low.
- R2: For opcode class 0 (plain instruction), completion with `ps_trace`=1 requests vector 0x000C before the next fetch. With `ps_trace`=0 it grants `fetch_go` directly.
- R3: For class 1 (interrupt return), the trace trap at its own boundary follows `ld_trace`, the trace bit of the restored PS.
- R4: For class 2 (trace-deferring return), its own boundary never traps. A following instruction that completes with `ps_trace`=1 then traps.
- R5: An interrupt with `irq_prio` > `cur_prio` is serviced ahead of a pending trace trap. Acknowledging any service clears the trace flag, so the trace is taken later when the handler's class 1 return restores the trace bit. With `irq_prio` <= `cur_prio` no interrupt is taken.
- R6: Classes 3 (wait) and 4 (priority set) produce no trace trap when `kernel`=1. When `kernel`=0 they are traced like class 0.
- R7: An abort strobe clears the trace flag and services only `abort_vec`. An abort wins over a completion strobe in the same cycle.
- R8: Class 5 (reset) keeps `reset_busy` high for exactly RST_CYCLES (default 8) cycles. `pirq_cancel` is high only in the last of them, and no interrupt is taken at the boundary that ends the wait.
- R9: A class 5 instruction completed with `ps_trace`=1 raises the trace trap after its wait.
- R10: Class 6 (trap instruction) services `done_vec` first, ahead of interrupts and trace.
- R11: While `svc_valid` is high and `svc_ready` low, `svc_valid` stays high and `svc_vec` is unchanged. After a transfer a new boundary decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Instruction completion strobe |
| done_op | input | 3 | Opcode class of the completing instruction |
| kernel | input | 1 | Current mode is kernel |
| ps_trace | input | 1 | Trace bit of the PS in effect for the instruction |
| ld_trace | input | 1 | Trace bit of the PS loaded by a return instruction |
| done_vec | input | 16 | Vector of a trap instruction |
| instr_abort | input | 1 | Instruction abort strobe |
| abort_vec | input | 16 | Vector for the abort |
| irq_req | input | 1 | Interrupt request |
| irq_prio | input | 3 | Priority of the request |
| irq_vec | input | 16 | Vector of the request |
| cur_prio | input | 3 | Current processor priority |
| svc_valid | output | 1 | Service request valid |
| svc_vec | output | 16 | Service vector address |
| svc_ready | input | 1 | Datapath accepts the service push |
| fetch_go | output | 1 | Boundary grants the next instruction fetch |
| reset_busy | output | 1 | RESET wait in progress |
| pirq_cancel | output | 1 | Cancel all software interrupt requests |

## Verification
Every cycle, assertions check four things: the service handshake stays stable under back-pressure, the reset counter stays in range, the wait and the outputs are mutually quiet with a single cancel pulse and no interrupt grant right after it, and at most one source is granted while an abort or an acknowledge leaves the trace flag clear. The opcode-dependent trace rules can only be shown by the bench's scenarios. These are the deferral after a trace-deferring return, the immediate trap after an interrupt return, and the mode-dependent tracing of wait and priority set. The same holds for the interrupt-before-trace order across all priorities and for the exact wait length.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  typedef enum logic [2:0] {
    OPC_OTHER = 3'd0,
    OPC_RTI   = 3'd1,
    OPC_RTT   = 3'd2,
    OPC_WAIT  = 3'd3,
    OPC_SPL   = 3'd4,
    OPC_RESET = 3'd5,
    OPC_TRAP  = 3'd6
  } opc_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DECIDE = 2'd1,
    ST_SVC    = 2'd2,
    ST_RWAIT  = 2'd3
  } st_e;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_ABORT = 3'd1,
    SRC_TRAP  = 3'd2,
    SRC_IRQ   = 3'd3,
    SRC_TRACE = 3'd4
  } src_e;

  localparam int NUM_SRC = 4;
endpackage

// File: rtl/tsq_trace_flag.sv
module tsq_trace_flag
  import tsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       kill,
  input  logic [2:0] op,
  input  logic       kernel,
  input  logic       ps_trace,
  input  logic       ld_trace,
  output logic       pend
);
  logic nxt;
  opc_e opc;

  assign opc = opc_e'(op);

  always_comb begin
    unique case (opc)
      OPC_RTI:           nxt = ld_trace;
      OPC_RTT:           nxt = 1'b0;
      OPC_WAIT, OPC_SPL: nxt = kernel ? 1'b0 : ps_trace;
      default:           nxt = ps_trace;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       pend <= 1'b0;
    else if (kill) pend <= 1'b0;
    else if (load) pend <= nxt;
  end

  AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    kill |=> !pend); // R7
endmodule

// File: rtl/tsq_reset_timer.sv
module tsq_reset_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= TOP;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign last = busy && (cnt == '0);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= TOP)); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
    (last && !start) |=> !busy); // R8
endmodule

// File: rtl/tsq_arbiter.sv
module tsq_arbiter
  import tsq_pkg::*;
#(
  parameter int VEC_W  = 16,
  parameter int PRIO_W = 3,
  parameter logic [VEC_W-1:0] TRACE_VEC = VEC_W'(12)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_p,
  input  logic [VEC_W-1:0]  abort_vec,
  input  logic              trap_p,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              irq_req,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_mask,
  input  logic              trace_p,
  output logic              any,
  output src_e              src,
  output logic [VEC_W-1:0]  vec
);
  logic [NUM_SRC-1:0]     req;
  logic [NUM_SRC-1:0]     gnt;
  logic [VEC_W-1:0]       vtab [NUM_SRC];
  src_e                   stab [NUM_SRC];
  logic                   irq_ok;

  assign irq_ok = irq_req && !irq_mask && (irq_prio > cur_prio);

  assign req  = {trace_p, irq_ok, trap_p, abort_p};
  assign vtab[0] = abort_vec;
  assign vtab[1] = trap_vec;
  assign vtab[2] = irq_vec;
  assign vtab[3] = TRACE_VEC;
  assign stab[0] = SRC_ABORT;
  assign stab[1] = SRC_TRAP;
  assign stab[2] = SRC_IRQ;
  assign stab[3] = SRC_TRACE;

  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    src   = SRC_NONE;
    vec   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req[i] && !found) begin
        found  = 1'b1;
        gnt[i] = 1'b1;
        src    = stab[i];
        vec    = vtab[i];
      end
    end
    any = found;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R10
  AST_ABORT_FIRST: assert property (@(posedge clk) disable iff (rst)
    abort_p |-> (src == SRC_ABORT)); // R7
endmodule

// File: rtl/trace_irq_seq.sv
module trace_irq_seq
  import tsq_pkg::*;
#(
  parameter int VEC_W      = 16,
  parameter int PRIO_W     = 3,
  parameter int OPC_W      = 3,
  parameter int RST_CYCLES = 8,
  parameter logic [VEC_W-1:0] TRACE_VEC = VEC_W'(12)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_done,
  input  logic [OPC_W-1:0]  done_op,
  input  logic              kernel,
  input  logic              ps_trace,
  input  logic              ld_trace,
  input  logic [VEC_W-1:0]  done_vec,
  input  logic              instr_abort,
  input  logic [VEC_W-1:0]  abort_vec,
  input  logic              irq_req,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [VEC_W-1:0]  irq_vec,
  input  logic [PRIO_W-1:0] cur_prio,
  output logic              svc_valid,
  output logic [VEC_W-1:0]  svc_vec,
  input  logic              svc_ready,
  output logic              fetch_go,
  output logic              reset_busy,
  output logic              pirq_cancel
);
  st_e              st;
  logic             abort_p, trap_p, post_rst;
  logic [VEC_W-1:0] abort_vq, trap_vq, svc_vq;
  src_e             svc_src;

  logic             acc_abort, acc_done, is_reset, ack;
  logic             trace_pend, tmr_last, tmr_busy;
  logic             arb_any;
  src_e             arb_src;
  logic [VEC_W-1:0] arb_vec;

  assign acc_abort = (st == ST_RUN) && instr_abort;
  assign acc_done  = (st == ST_RUN) && instr_done && !instr_abort;
  assign is_reset  = (opc_e'(done_op[2:0]) == OPC_RESET);
  assign ack       = (st == ST_SVC) && svc_ready;

  tsq_trace_flag u_trace (
    .clk      (clk),
    .rst      (rst),
    .load     (acc_done),
    .kill     (acc_abort || ack),
    .op       (done_op[2:0]),
    .kernel   (kernel),
    .ps_trace (ps_trace),
    .ld_trace (ld_trace),
    .pend     (trace_pend)
  );

  tsq_reset_timer #(.CYC(RST_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (acc_done && is_reset),
    .busy  (tmr_busy),
    .last  (tmr_last)
  );

  tsq_arbiter #(.VEC_W(VEC_W), .PRIO_W(PRIO_W), .TRACE_VEC(TRACE_VEC)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .abort_p   (abort_p),
    .abort_vec (abort_vq),
    .trap_p    (trap_p),
    .trap_vec  (trap_vq),
    .irq_req   (irq_req),
    .irq_prio  (irq_prio),
    .cur_prio  (cur_prio),
    .irq_vec   (irq_vec),
    .irq_mask  (post_rst),
    .trace_p   (trace_pend),
    .any       (arb_any),
    .src       (arb_src),
    .vec       (arb_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_RUN;
      abort_p  <= 1'b0;
      trap_p   <= 1'b0;
      post_rst <= 1'b0;
      abort_vq <= '0;
      trap_vq  <= '0;
      svc_vq   <= '0;
      svc_src  <= SRC_NONE;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (acc_abort) begin
            abort_p  <= 1'b1;
            abort_vq <= abort_vec;
            st       <= ST_DECIDE;
          end else if (acc_done) begin
            if (opc_e'(done_op[2:0]) == OPC_TRAP) begin
              trap_p  <= 1'b1;
              trap_vq <= done_vec;
            end
            st <= is_reset ? ST_RWAIT : ST_DECIDE;
          end
        end
        ST_RWAIT: begin
          if (tmr_last) begin
            post_rst <= 1'b1;
            st       <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          post_rst <= 1'b0;
          if (arb_any) begin
            svc_vq  <= arb_vec;
            svc_src <= arb_src;
            st      <= ST_SVC;
          end else begin
            st <= ST_RUN;
          end
        end
        ST_SVC: begin
          if (svc_ready) begin
            if (svc_src == SRC_ABORT) abort_p <= 1'b0;
            if (svc_src == SRC_TRAP)  trap_p  <= 1'b0;
            st <= ST_DECIDE;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign svc_valid   = (st == ST_SVC);
  assign svc_vec     = svc_vq;
  assign fetch_go    = (st == ST_DECIDE) && !arb_any;
  assign reset_busy  = tmr_busy;
  assign pirq_cancel = tmr_last;

  AST_SVC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && !svc_ready) |=> (svc_valid && $stable(svc_vec))); // R11
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    reset_busy |-> (!svc_valid && !fetch_go)); // R8
  AST_CANCEL_PULSE: assert property (@(posedge clk) disable iff (rst)
    pirq_cancel |=> (!pirq_cancel && !reset_busy)); // R8
  AST_NO_IRQ_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    pirq_cancel |=> (arb_src != SRC_IRQ)); // R8
  AST_ABORT_NO_TRACE: assert property (@(posedge clk) disable iff (rst)
    acc_abort |=> !trace_pend); // R7
endmodule

// File: tb/trace_irq_seq_tb_top.sv
`timescale 1ns/1ps
module trace_irq_seq_tb_top;
  localparam logic [15:0] TRV = 16'h000C;
  localparam logic [15:0] IRV = 16'h00A0;
  localparam logic [15:0] TPV = 16'h001C;
  localparam logic [15:0] ABV = 16'h0004;
  localparam int EV_NONE = 0, EV_FETCH = 1, EV_SVC = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic instr_done = 0, kernel = 0, ps_trace = 0, ld_trace = 0, instr_abort = 0;
  logic [2:0] done_op = 0, irq_prio = 3'd5, cur_prio = 3'd7;
  logic [15:0] done_vec = TPV, abort_vec = ABV, irq_vec = IRV;
  logic irq_req = 0, svc_ready = 0;
  logic svc_valid, fetch_go, reset_busy, pirq_cancel;
  logic [15:0] svc_vec;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trace_irq_seq dut_i (
    .clk(clk), .rst(rst), .instr_done(instr_done), .done_op(done_op),
    .kernel(kernel), .ps_trace(ps_trace), .ld_trace(ld_trace),
    .done_vec(done_vec), .instr_abort(instr_abort), .abort_vec(abort_vec),
    .irq_req(irq_req), .irq_prio(irq_prio), .irq_vec(irq_vec),
    .cur_prio(cur_prio), .svc_valid(svc_valid), .svc_vec(svc_vec),
    .svc_ready(svc_ready), .fetch_go(fetch_go), .reset_busy(reset_busy),
    .pirq_cancel(pirq_cancel)
  );

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic do_instr(input logic [2:0] op, input logic k, input logic pt, input logic lt);
    done_op = op; kernel = k; ps_trace = pt; ld_trace = lt; instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
  endtask

  task automatic get_event(output int kind, output logic [15:0] vec);
    int waited = 0;
    kind = EV_NONE; vec = '0;
    while (waited < 200) begin
      if (fetch_go) begin
        kind = EV_FETCH;
        @(negedge clk);
        return;
      end
      if (svc_valid) begin
        kind = EV_SVC; vec = svc_vec;
        if (vec == IRV) irq_req = 1'b0;
        svc_ready = 1'b1;
        @(negedge clk);
        svc_ready = 1'b0;
        return;
      end
      waited++;
      @(negedge clk);
    end
  endtask

  task automatic expect_evt(input string tag, input int ekind, input logic [15:0] evec);
    int kind; logic [15:0] vec;
    get_event(kind, vec);
    chk(kind == ekind && (ekind != EV_SVC || vec == evec), tag,
        (kind << 16) | int'(vec), (ekind << 16) | int'(evec));
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R2 plain";
      1: return "R3 int-return";
      2: return "R4 deferring-return";
      3, 4: return "R6 wait/spl";
      5: return "R9 reset";
      default: return "R10 trap-instr";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(!svc_valid && !fetch_go && !reset_busy && !pirq_cancel, "R1 reset state",
        {svc_valid, fetch_go, reset_busy, pirq_cancel}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!svc_valid && !fetch_go && !reset_busy && !pirq_cancel, "R1 idle after release",
        {svc_valid, fetch_go, reset_busy, pirq_cancel}, 0);

    // Sweep over opcode class, mode, trace bit and restored trace bit
    for (int op = 0; op < 7; op++)
      for (int k = 0; k < 2; k++)
        for (int pt = 0; pt < 2; pt++)
          for (int lt = 0; lt < 2; lt++) begin
            bit tr;
            case (op)
              0, 5: tr = pt[0];
              1: tr = lt[0];
              2: tr = 1'b0;
              3, 4: tr = k[0] ? 1'b0 : pt[0];
              default: tr = 1'b0;
            endcase
            do_instr(op[2:0], k[0], pt[0], lt[0]);
            if (op == 6) expect_evt(op_tag(op), EV_SVC, TPV);
            else if (tr) expect_evt(op_tag(op), EV_SVC, TRV);
            expect_evt(op_tag(op), EV_FETCH, 16'h0);
          end

    // R4: deferred trace lands after the next instruction
    do_instr(3'd2, 1'b1, 1'b0, 1'b1);
    expect_evt("R4 no trap at return", EV_FETCH, 16'h0);
    do_instr(3'd0, 1'b1, 1'b1, 1'b0);
    expect_evt("R4 trap after next", EV_SVC, TRV);
    expect_evt("R4 fetch after trap", EV_FETCH, 16'h0);

    // R5: interrupt vs trace over all processor priorities
    for (int cp = 0; cp < 8; cp++)
      for (int pt = 0; pt < 2; pt++) begin
        cur_prio = cp[2:0]; irq_req = 1'b1;
        do_instr(3'd0, 1'b1, pt[0], 1'b0);
        if (5 > cp) expect_evt("R5 irq first", EV_SVC, IRV);
        else if (pt != 0) expect_evt("R5 trace when irq blocked", EV_SVC, TRV);
        expect_evt("R5 fetch", EV_FETCH, 16'h0);
        irq_req = 1'b0;
        if (5 > cp && pt != 0) begin
          do_instr(3'd1, 1'b1, 1'b0, 1'b1);
          expect_evt("R5 trace after handler return", EV_SVC, TRV);
          expect_evt("R5 fetch after return", EV_FETCH, 16'h0);
        end
      end

    // R10: trap instruction ahead of interrupt and trace
    cur_prio = 3'd0; irq_req = 1'b1;
    do_instr(3'd6, 1'b1, 1'b1, 1'b0);
    expect_evt("R10 trap vector first", EV_SVC, TPV);
    expect_evt("R10 irq second", EV_SVC, IRV);
    expect_evt("R10 fetch", EV_FETCH, 16'h0);
    cur_prio = 3'd7;

    // R7: abort drops trace, wins over completion
    instr_abort = 1'b1; instr_done = 1'b1; ps_trace = 1'b1; done_op = 3'd0;
    @(negedge clk);
    instr_abort = 1'b0; instr_done = 1'b0;
    expect_evt("R7 abort vector", EV_SVC, ABV);
    expect_evt("R7 no trace after abort", EV_FETCH, 16'h0);

    // R11: back-pressure hold
    do_instr(3'd0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(svc_valid && svc_vec == TRV, "R11 hold under back-pressure", int'(svc_vec), int'(TRV));
      @(negedge clk);
    end
    expect_evt("R11 transfer", EV_SVC, TRV);
    expect_evt("R11 next decision", EV_FETCH, 16'h0);

    // R8: reset wait length, cancel pulse, interrupt masked at its end
    begin
      int bc = 0, cancel_at = -1, cancel_n = 0;
      cur_prio = 3'd0; irq_req = 1'b1;
      do_instr(3'd5, 1'b1, 1'b0, 1'b0);
      while (reset_busy && bc < 100) begin
        bc++;
        if (pirq_cancel) begin cancel_at = bc; cancel_n++; end
        chk(!svc_valid && !fetch_go, "R8 quiet during wait", {svc_valid, fetch_go}, 0);
        @(negedge clk);
      end
      chk(bc == 8, "R8 wait length", bc, 8);
      chk(cancel_at == 8 && cancel_n == 1, "R8 cancel in last cycle", cancel_at, 8);
      expect_evt("R8 no interrupt after reset", EV_FETCH, 16'h0);
      irq_req = 1'b0; cur_prio = 3'd7;
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule